// File: doc/BRIEF.md
# DDR SDRAM Command Timing Scheduler

This block sits between a memory controller's request logic and a four-bank DDR SDRAM command bus. The controller offers one request at a time: activate, read, write, precharge or mode-register-set, with a bank number and an address word. The scheduler holds the request until every spacing rule that applies to it has been met. It then drives the command onto registered chip-select, row-strobe, column-strobe, write-enable, bank and address outputs in the next cycle.

The scheduler keeps an open/closed flag and three down-counters for each bank. It keeps bus-wide counters for read/write turnaround and for the gap after a mode-register write. Burst length and CAS latency come from the last accepted mode-register-set. The spacing rules scale with these two values. Address bit 10 selects between a single-bank and an all-bank precharge, and it requests auto-precharge on reads and writes.

A request that cannot succeed is consumed at once. It issues nothing and raises a one-cycle error flag. The rule that applies depends on the request:
- a read or write to a closed bank
- an activate to an open bank
- a mode-register-set while any bank is open
- an undefined request code

Top module: `ddr_cmd_sched`

## Requirements
- R1: After reset, the command outputs are deselected (chip select, row strobe, column strobe and write enable all high) and the error flag is low. All banks are closed. Burst length is 4 and CAS latency is 2.
- R2: Request codes are 0 activate, 1 read, 2 write, 3 precharge and 4 mode-register-set. An accepted legal request appears one cycle later with chip select low and {row strobe, column strobe, write enable} set as follows: activate 011, read 101, write 100, precharge 010, mode-register-set 000. The bank output equals the requested bank. In every other cycle chip select is high.
- R3: A read or write to a closed bank, an activate to an open bank, a mode-register-set while any bank is open, and request codes 5 to 7 are accepted in the same cycle without waiting. Each one issues no command and sets the error flag for exactly one cycle.
- R4: An activate and a later read or write to the same bank are at least ceil(tRCD/tCK) cycles apart. A precharge and a later activate of the same bank are at least ceil(tRP/tCK) cycles apart.
- R5: A read is followed by a precharge of the same bank no sooner than BL/2 cycles later. A write is followed by a precharge of the same bank no sooner than 1+BL/2+ceil(tWR/tCK) cycles later.
- R6: A write and any later read are at least 2+BL/2 cycles apart.
- R7: A read and any later write are at least 2+BL/2 cycles apart at CAS latency 2, and at least 3+BL/2 cycles apart at CAS latency 2.5.
- R8: No command is accepted in the cycle after a mode-register-set. A mode-register-set waits until every bank has finished its precharge time. Address bits [2:0] set the burst length: 1 gives 2, 2 gives 4, 3 gives 8. Address bits [6:4] set the CAS latency: 2 gives 2, 6 gives 2.5. Any other code leaves that setting unchanged. A rejected mode-register-set changes nothing.
- R9: A precharge with address bit 10 high closes all banks and waits for every open bank's precharge spacing. With bit 10 low it closes only the addressed bank. The issued address carries only bit 10.
- R10: A read or write with address bit 10 high closes its bank. A later activate of that bank waits at least BL/2+ceil(tRP/tCK) cycles after a read, or 1+BL/2+ceil(tWR/tCK)+ceil(tRP/tCK) cycles after a write, or longer if an earlier write's recovery time ends later.
- R11: An activate drives all 13 address bits as the row. A read or write drives address bits 0 to 11 as given (column bits 0 to 9 and 11, auto-precharge on bit 10) and drives bit 12 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken at this edge |
| req_cmd | input | 3 | Request code |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row, column or mode word |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a | output | 13 | Address bus |
| cmd_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions check several properties on every cycle:
- a selected bus never carries the all-high code
- no command follows a mode-register-set or a rejected request
- reads and writes only reach open banks, and activates only reach closed banks
- reads and writes never sit back to back
- column commands never drive bit 12

Exact spacings depend on the programmed burst length and latency, so only the bench's request sequences can show them, together with the auto-precharge reopen delay and the ignored effect of a rejected mode write. The bench measures the distance between accepted requests and compares it against values worked out from the rules.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

  typedef enum logic [2:0] {
    REQ_ACT = 3'd0,
    REQ_RD  = 3'd1,
    REQ_WR  = 3'd2,
    REQ_PRE = 3'd3,
    REQ_MRS = 3'd4
  } req_e;

  // {ras_n, cas_n, we_n} for each request code
  function automatic logic [2:0] strobe_code(input logic [2:0] code);
    case (code)
      REQ_ACT: strobe_code = 3'b011;
      REQ_RD:  strobe_code = 3'b101;
      REQ_WR:  strobe_code = 3'b100;
      REQ_PRE: strobe_code = 3'b010;
      REQ_MRS: strobe_code = 3'b000;
      default: strobe_code = 3'b111;
    endcase
  endfunction

  function automatic int cyc_ceil(input int t_ps, input int tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

endpackage

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       do_mrs,
  input  logic [6:0] mode_word,
  output logic [2:0] bl_half,
  output logic       cl_half
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bl_half <= 3'd2;
      cl_half <= 1'b0;
    end else if (do_mrs) begin
      case (mode_word[2:0])
        3'd1:    bl_half <= 3'd1;
        3'd2:    bl_half <= 3'd2;
        3'd3:    bl_half <= 3'd4;
        default: bl_half <= bl_half;
      endcase
      case (mode_word[6:4])
        3'd2:    cl_half <= 1'b0;
        3'd6:    cl_half <= 1'b1;
        default: cl_half <= cl_half;
      endcase
    end
  end

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (rst) $countones(bl_half) == 1); // R8

endmodule

// File: rtl/ddr_bus_timer.sv
module ddr_bus_timer #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       do_rd,
  input  logic       do_wr,
  input  logic       do_mrs,
  input  logic [2:0] bl_half,
  input  logic       cl_half,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       cmd_ok
);

  logic [CNT_W-1:0] rd_cnt, wr_cnt, mrs_cnt, bl_c, w2r, r2w;

  assign bl_c = CNT_W'(bl_half);
  assign w2r  = bl_c + CNT_W'(1);
  assign r2w  = bl_c + CNT_W'(1) + CNT_W'(cl_half);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt  <= '0;
      wr_cnt  <= '0;
      mrs_cnt <= '0;
    end else begin
      rd_cnt  <= (rd_cnt  != '0) ? rd_cnt  - 1'b1 : rd_cnt;
      wr_cnt  <= (wr_cnt  != '0) ? wr_cnt  - 1'b1 : wr_cnt;
      mrs_cnt <= (mrs_cnt != '0) ? mrs_cnt - 1'b1 : mrs_cnt;
      if (do_wr) rd_cnt  <= (rd_cnt > w2r) ? rd_cnt : w2r;
      if (do_rd) wr_cnt  <= (wr_cnt > r2w) ? wr_cnt : r2w;
      if (do_mrs) mrs_cnt <= CNT_W'(1);
    end
  end

  assign rd_ok  = (rd_cnt == '0);
  assign wr_ok  = (wr_cnt == '0);
  assign cmd_ok = (mrs_cnt == '0);

  AST_RD_THEN_NO_WR:  assert property (@(posedge clk) disable iff (rst) do_rd |=> !do_wr); // R7
  AST_WR_THEN_NO_RD:  assert property (@(posedge clk) disable iff (rst) do_wr |=> !do_rd); // R6
  AST_MRS_QUIET:      assert property (@(posedge clk) disable iff (rst) do_mrs |=> !(do_rd || do_wr || do_mrs)); // R8

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
  parameter int RCD_CYC = 4,
  parameter int RP_CYC  = 4,
  parameter int WR_CYC  = 3,
  parameter int CNT_W   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       do_act,
  input  logic       do_rd,
  input  logic       do_wr,
  input  logic       do_pre,
  input  logic       auto_pre,
  input  logic [2:0] bl_half,
  output logic       is_open,
  output logic       act_ok,
  output logic       rw_ok,
  output logic       pre_ok
);

  localparam logic [CNT_W-1:0] RCD_L = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] RP_L  = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RP_F  = CNT_W'(RP_CYC);
  localparam logic [CNT_W-1:0] WR_F  = CNT_W'(WR_CYC);

  logic [CNT_W-1:0] act_cnt, rw_cnt, pre_cnt;
  logic [CNT_W-1:0] rd_pre, wr_pre, rd_hold, wr_hold;

  // last blocked cycle before the precharge may go, relative to now
  assign rd_pre  = CNT_W'(bl_half) - CNT_W'(1);
  assign wr_pre  = CNT_W'(bl_half) + WR_F;
  assign rd_hold = (pre_cnt > rd_pre) ? pre_cnt : rd_pre;
  assign wr_hold = (pre_cnt > wr_pre) ? pre_cnt : wr_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      act_cnt <= '0;
      rw_cnt  <= '0;
      pre_cnt <= '0;
    end else begin
      act_cnt <= (act_cnt != '0) ? act_cnt - 1'b1 : act_cnt;
      rw_cnt  <= (rw_cnt  != '0) ? rw_cnt  - 1'b1 : rw_cnt;
      pre_cnt <= (pre_cnt != '0) ? pre_cnt - 1'b1 : pre_cnt;
      if (do_act) begin
        is_open <= 1'b1;
        rw_cnt  <= RCD_L;
      end
      if (do_rd) begin
        if (auto_pre) begin
          is_open <= 1'b0;
          act_cnt <= rd_hold + RP_F;
        end else begin
          pre_cnt <= rd_hold;
        end
      end
      if (do_wr) begin
        if (auto_pre) begin
          is_open <= 1'b0;
          act_cnt <= wr_hold + RP_F;
        end else begin
          pre_cnt <= wr_hold;
        end
      end
      if (do_pre) begin
        is_open <= 1'b0;
        act_cnt <= (act_cnt > RP_L) ? act_cnt : RP_L;
      end
    end
  end

  assign act_ok = (act_cnt == '0);
  assign rw_ok  = (rw_cnt  == '0);
  assign pre_ok = (pre_cnt == '0);

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (rst) do_act |-> !is_open); // R3
  AST_RW_ONLY_OPEN:    assert property (@(posedge clk) disable iff (rst) (do_rd || do_wr) |-> is_open); // R3
  AST_RCD_HELD:        assert property (@(posedge clk) disable iff (rst) ((RCD_CYC > 1) && do_act) |=> !(do_rd || do_wr)); // R4
  AST_RP_HELD:         assert property (@(posedge clk) disable iff (rst) ((RP_CYC > 1) && do_pre) |=> !do_act); // R4

endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched #(
  parameter int TCK_PS    = 5000,
  parameter int TRCD_PS   = 20000,
  parameter int TRP_PS    = 20000,
  parameter int TWR_PS    = 15000,
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [2:0]                   req_cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         cs_n,
  output logic                         ras_n,
  output logic                         cas_n,
  output logic                         we_n,
  output logic [$clog2(NUM_BANKS)-1:0] ba,
  output logic [ADDR_W-1:0]            a,
  output logic                         cmd_err
);
  import ddr_sched_pkg::*;

  localparam int BA_W    = $clog2(NUM_BANKS);
  localparam int RCD_CYC = cyc_ceil(TRCD_PS, TCK_PS);
  localparam int RP_CYC  = cyc_ceil(TRP_PS, TCK_PS);
  localparam int WR_CYC  = cyc_ceil(TWR_PS, TCK_PS);
  localparam int CNT_W   = $clog2(RCD_CYC + RP_CYC + WR_CYC + 8);
  localparam logic [ADDR_W-1:0] COL_MASK = ADDR_W'(13'h0FFF);
  localparam logic [ADDR_W-1:0] AP_BIT   = ADDR_W'(13'h0400);

  logic [2:0]           bl_half;
  logic                 cl_half;
  logic                 rd_ok, wr_ok, cmd_ok;
  logic [NUM_BANKS-1:0] bank_open, act_ok, rw_ok, pre_ok, hit, act_b, pre_b;
  logic                 sel_open, err_c, time_c, accept, issue;
  logic                 do_act, do_rd, do_wr, do_pre, do_mrs;
  logic [ADDR_W-1:0]    addr_out;

  assign sel_open = bank_open[req_bank];

  always_comb begin
    err_c  = 1'b0;
    time_c = 1'b0;
    case (req_cmd)
      REQ_ACT: begin
        err_c  = sel_open;
        time_c = act_ok[req_bank] & cmd_ok;
      end
      REQ_RD: begin
        err_c  = !sel_open;
        time_c = rw_ok[req_bank] & rd_ok & cmd_ok;
      end
      REQ_WR: begin
        err_c  = !sel_open;
        time_c = rw_ok[req_bank] & wr_ok & cmd_ok;
      end
      REQ_PRE: begin
        time_c = cmd_ok & (req_addr[10] ? (&(pre_ok | ~bank_open))
                                        : (pre_ok[req_bank] | !sel_open));
      end
      REQ_MRS: begin
        err_c  = |bank_open;
        time_c = (&act_ok) & cmd_ok;
      end
      default: err_c = 1'b1;
    endcase
  end

  assign req_ready = err_c | time_c;
  assign accept    = req_valid & req_ready;
  assign issue     = accept & !err_c;
  assign do_act    = issue & (req_cmd == REQ_ACT);
  assign do_rd     = issue & (req_cmd == REQ_RD);
  assign do_wr     = issue & (req_cmd == REQ_WR);
  assign do_pre    = issue & (req_cmd == REQ_PRE);
  assign do_mrs    = issue & (req_cmd == REQ_MRS);

  always_comb begin
    case (req_cmd)
      REQ_RD, REQ_WR: addr_out = req_addr & COL_MASK;
      REQ_PRE:        addr_out = req_addr & AP_BIT;
      default:        addr_out = req_addr;
    endcase
  end

  ddr_mode_reg i_mode (
    .clk       (clk),
    .rst       (rst),
    .do_mrs    (do_mrs),
    .mode_word (req_addr[6:0]),
    .bl_half   (bl_half),
    .cl_half   (cl_half)
  );

  ddr_bus_timer #(.CNT_W(CNT_W)) i_bus (
    .clk     (clk),
    .rst     (rst),
    .do_rd   (do_rd),
    .do_wr   (do_wr),
    .do_mrs  (do_mrs),
    .bl_half (bl_half),
    .cl_half (cl_half),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok),
    .cmd_ok  (cmd_ok)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    assign hit[gi]   = (req_bank == BA_W'(gi));
    assign act_b[gi] = do_act & hit[gi];
    assign pre_b[gi] = do_pre & (req_addr[10] | hit[gi]);

    ddr_bank_timer #(
      .RCD_CYC (RCD_CYC),
      .RP_CYC  (RP_CYC),
      .WR_CYC  (WR_CYC),
      .CNT_W   (CNT_W)
    ) i_bank (
      .clk      (clk),
      .rst      (rst),
      .do_act   (act_b[gi]),
      .do_rd    (do_rd & hit[gi]),
      .do_wr    (do_wr & hit[gi]),
      .do_pre   (pre_b[gi]),
      .auto_pre (req_addr[10]),
      .bl_half  (bl_half),
      .is_open  (bank_open[gi]),
      .act_ok   (act_ok[gi]),
      .rw_ok    (rw_ok[gi]),
      .pre_ok   (pre_ok[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n    <= 1'b1;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba      <= '0;
      a       <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= accept & err_c;
      if (issue) begin
        cs_n <= 1'b0;
        {ras_n, cas_n, we_n} <= strobe_code(req_cmd);
        ba   <= req_bank;
        a    <= addr_out;
      end else begin
        cs_n <= 1'b1;
        {ras_n, cas_n, we_n} <= 3'b111;
        ba   <= '0;
        a    <= '0;
      end
    end
  end

  AST_SELECT_HAS_CMD: assert property (@(posedge clk) disable iff (rst) !cs_n |-> !(ras_n && cas_n && we_n)); // R2
  AST_ERR_NO_CMD:     assert property (@(posedge clk) disable iff (rst) cmd_err |-> cs_n); // R3
  AST_MRS_GAP:        assert property (@(posedge clk) disable iff (rst) (!cs_n && !ras_n && !cas_n && !we_n) |=> cs_n); // R8
  AST_COL_TOP_LOW:    assert property (@(posedge clk) disable iff (rst) (!cs_n && ras_n && !cas_n) |-> !a[ADDR_W-1]); // R11

endmodule

// File: tb/test_ddr_cmd_sched.sv
module test_ddr_cmd_sched;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_addr = '0;
  logic        cs_n, ras_n, cas_n, we_n, cmd_err;
  logic [1:0]  ba;
  logic [12:0] a;

  int applied = 0;
  int miscmp  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_sched i_ddr_cmd_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_addr(req_addr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a(a), .cmd_err(cmd_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      miscmp = miscmp + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int rq, input int act, input int exp);
    applied = applied + 1;
    if (!ok) begin
      miscmp = miscmp + 1;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // {cmd3, bank2, addr13, gap5, err1, rcw3, exp_a13, req4}
  localparam int NV = 27;
  localparam logic [43:0] VEC [NV] = '{
    {3'd4, 2'd0, 13'h0023, 5'd1,  1'b0, 3'b000, 13'h0023, 4'd8},  // R8 BL8 CL2
    {3'd0, 2'd0, 13'h1ABC, 5'd2,  1'b0, 3'b011, 13'h1ABC, 4'd8},  // R8 gap after mode write
    {3'd1, 2'd0, 13'h0005, 5'd4,  1'b0, 3'b101, 13'h0005, 4'd4},  // R4 tRCD
    {3'd2, 2'd0, 13'h0010, 5'd6,  1'b0, 3'b100, 13'h0010, 4'd7},  // R7 2+BL/2
    {3'd1, 2'd0, 13'h0420, 5'd6,  1'b0, 3'b101, 13'h0420, 4'd6},  // R6 write to read, auto-precharge
    {3'd0, 2'd0, 13'h0777, 5'd8,  1'b0, 3'b011, 13'h0777, 4'd10}, // R10 BL/2+RP
    {3'd0, 2'd1, 13'h0003, 5'd1,  1'b0, 3'b011, 13'h0003, 4'd2},  // R2
    {3'd1, 2'd2, 13'h0000, 5'd1,  1'b1, 3'b111, 13'h0000, 4'd3},  // R3 read closed bank
    {3'd0, 2'd1, 13'h0000, 5'd1,  1'b1, 3'b111, 13'h0000, 4'd3},  // R3 activate open bank
    {3'd2, 2'd1, 13'h1FFF, 5'd2,  1'b0, 3'b100, 13'h0FFF, 4'd11}, // R11 column mapping, auto-precharge
    {3'd3, 2'd0, 13'h0123, 5'd1,  1'b0, 3'b010, 13'h0000, 4'd9},  // R9 single bank
    {3'd0, 2'd1, 13'h0100, 5'd11, 1'b0, 3'b011, 13'h0100, 4'd10}, // R10 1+BL/2+WR+RP
    {3'd0, 2'd2, 13'h0055, 5'd1,  1'b0, 3'b011, 13'h0055, 4'd2},  // R2
    {3'd3, 2'd3, 13'h0400, 5'd1,  1'b0, 3'b010, 13'h0400, 4'd9},  // R9 all banks
    {3'd4, 2'd0, 13'h0061, 5'd4,  1'b0, 3'b000, 13'h0061, 4'd9},  // R9 all closed, waits RP; BL2 CL2.5
    {3'd0, 2'd3, 13'h0000, 5'd2,  1'b0, 3'b011, 13'h0000, 4'd8},  // R8
    {3'd1, 2'd3, 13'h0001, 5'd4,  1'b0, 3'b101, 13'h0001, 4'd4},  // R4
    {3'd2, 2'd3, 13'h0002, 5'd4,  1'b0, 3'b100, 13'h0002, 4'd7},  // R7 3+BL/2
    {3'd3, 2'd3, 13'h0000, 5'd5,  1'b0, 3'b010, 13'h0000, 4'd5},  // R5 write recovery
    {3'd0, 2'd0, 13'h0009, 5'd1,  1'b0, 3'b011, 13'h0009, 4'd2},  // R2
    {3'd4, 2'd0, 13'h0003, 5'd1,  1'b1, 3'b111, 13'h0000, 4'd3},  // R3 mode write with open bank
    {3'd7, 2'd0, 13'h0000, 5'd1,  1'b1, 3'b111, 13'h0000, 4'd3},  // R3 undefined code
    {3'd1, 2'd0, 13'h0003, 5'd2,  1'b0, 3'b101, 13'h0003, 4'd4},  // R4
    {3'd3, 2'd0, 13'h0000, 5'd1,  1'b0, 3'b010, 13'h0000, 4'd5},  // R5 read to precharge BL/2
    {3'd0, 2'd0, 13'h0000, 5'd4,  1'b0, 3'b011, 13'h0000, 4'd4},  // R4 tRP
    {3'd1, 2'd0, 13'h0000, 5'd4,  1'b0, 3'b101, 13'h0000, 4'd4},  // R4
    {3'd2, 2'd0, 13'h0000, 5'd4,  1'b0, 3'b100, 13'h0000, 4'd8}   // R8 rejected mode write kept BL2
  };

  task automatic apply(input logic [2:0] c, input logic [1:0] b, input logic [12:0] ad,
                       input int gap, input bit e, input logic [2:0] rcw,
                       input logic [12:0] ea, input int rq);
    int waits = 0;
    req_valid = 1'b1;
    req_cmd   = c;
    req_bank  = b;
    req_addr  = ad;
    #1;
    while (!req_ready && waits < 100) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(waits + 1 == gap, "acceptance gap", rq, waits + 1, gap);
    chk(cmd_err == e, "error flag", rq, cmd_err, e);
    if (e) begin
      chk(cs_n == 1'b1, "deselect on reject", rq, cs_n, 1);
    end else begin
      chk(cs_n == 1'b0, "chip select", rq, cs_n, 0);
      chk({ras_n, cas_n, we_n} == rcw, "strobe code", rq, {ras_n, cas_n, we_n}, rcw);
      chk(ba == b, "bank", rq, ba, b);
      chk(a == ea, "address", rq, a, ea);
    end
  endtask

  task automatic check_idle(input int rq);
    chk(cs_n && ras_n && cas_n && we_n, "deselected bus", rq,
        {cs_n, ras_n, cas_n, we_n}, 4'hF);
    chk(cmd_err == 1'b0, "error low", rq, cmd_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle(1); // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][43:41], VEC[i][40:39], VEC[i][38:26], int'(VEC[i][25:21]),
            VEC[i][20], VEC[i][19:17], VEC[i][16:4], int'(VEC[i][3:0]));
    end

    // R1: reset mid-run restores closed banks, BL4, CL2
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_idle(1);
    apply(3'd1, 2'd0, 13'h0000, 1, 1'b1, 3'b111, 13'h0000, 1); // R1 bank closed after reset
    apply(3'd0, 2'd0, 13'h0040, 1, 1'b0, 3'b011, 13'h0040, 1); // R1
    apply(3'd1, 2'd0, 13'h0000, 4, 1'b0, 3'b101, 13'h0000, 4); // R4
    apply(3'd3, 2'd0, 13'h0000, 2, 1'b0, 3'b010, 13'h0000, 5); // R5 BL/2 = 2 at default
    apply(3'd0, 2'd0, 13'h0000, 4, 1'b0, 3'b011, 13'h0000, 4); // R4
    apply(3'd2, 2'd0, 13'h0000, 4, 1'b0, 3'b100, 13'h0000, 1); // R1
    apply(3'd1, 2'd0, 13'h0000, 4, 1'b0, 3'b101, 13'h0000, 6); // R6 2+BL/2 at default
    @(negedge clk);
    check_idle(2); // R2 no request, no select

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule